// File: doc/BRIEF.md
# Scanline Framebuffer Fetch Address Generator

This block drives the read side of a display pipeline. At each frame-start pulse it captures a frame base address, a byte pitch between scanlines, a per-line length counted in 16-byte (128-bit) words, an active line count and a pixel format code. It then walks the frame one 128-bit word at a time, presenting one word address per request on a valid/ready handshake toward the memory side.

Fetching is paced by the fill level of the display FIFO downstream, counted in 16-byte chunks. Requests start once the level falls to the refill threshold or below. They keep flowing until the level reaches the stop threshold, so there is hysteresis between the two marks. The line length is programmed apart from the pitch, which lets a line occupy fewer bytes than the pitch, or round up to a whole word.

Only the 16-bit and 32-bit pixel codes start a frame. Any other code leaves the block idle until the next frame-start pulse. When the last word of the last active line has been accepted, the block goes idle and waits for the next frame-start pulse.

Top module: `fb_fetch_agen`

## Requirements
- R1: During and right after reset, `req_valid` and `frame_busy` are 0.
- R2: A frame-start pulse with a supported format and nonzero line and word counts makes `frame_busy` 1 from the next cycle. The first request address then equals the base captured with the pulse.
- R3: Within a line, the address of each accepted request is 16 greater than the one before it.
- R4: After `cfg_words` words have been accepted, the next line starts at the previous line's start address plus the pitch captured at frame start.
- R5: Exactly `cfg_lines` × `cfg_words` requests are accepted per frame. After that `frame_busy` and `req_valid` stay 0 until the next frame-start pulse.
- R6: Changing base, pitch, word or line count in mid-frame has no effect on the current frame. A new base is used from the next frame-start pulse.
- R7: Format code 1 selects 16-bit pixels and code 2 selects 32-bit pixels. `pix32` shows the code captured at the last frame start (1 for code 2). Codes 0 and 3 leave `frame_busy` 0.
- R8: From a paused state, no request is raised while `fifo_level` is above `thr_refill`. A request is raised once `fifo_level` is at or below it.
- R9: `req_valid` is 0 whenever `fifo_level` is at or above `thr_stop`. Once stopped, fetching stays paused for levels between the two thresholds. Once running, it keeps going for such levels.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_addr` holds its value.
- R11: A frame-start pulse during a busy frame abandons it and restarts at the newly supplied base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame start pulse |
| cfg_base | input | 32 | Frame base byte address |
| cfg_pitch | input | 16 | Byte distance between scanline starts |
| cfg_words | input | 10 | 128-bit words per line |
| cfg_lines | input | 12 | Active lines per frame |
| cfg_fmt | input | 2 | Pixel format code (1: 16-bit, 2: 32-bit) |
| thr_refill | input | 8 | Level at or below which fetching resumes |
| thr_stop | input | 8 | Level at or above which fetching pauses |
| fifo_level | input | 8 | FIFO fill level in 16-byte chunks |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Byte address of the requested 128-bit word |
| frame_busy | output | 1 | A frame is being fetched |
| pix32 | output | 1 | Captured format is 32-bit pixels |

## Verification
The hardest case is the hysteresis band. A FIFO level between the refill and stop marks must give opposite results depending on whether fetching was running or paused beforehand. The stimulus holds `req_ready` low so that no word is consumed. It then steps `fifo_level` through above-refill, at-refill, in-band, at-stop, in-band again and below-refill, checking `req_valid` and the held address at each step. Mid-frame reconfiguration and restart are reached by changing inputs between handshakes on a frame whose accepted addresses are logged.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;
    parameter int FF_ADDR_W  = 32;
    parameter int FF_PITCH_W = 16;
    parameter int FF_WORDS_W = 10;
    parameter int FF_LINES_W = 12;
    parameter int FF_LVL_W   = 8;
    parameter int FF_WORD_BYTES_LOG2 = 4;

    typedef enum logic [1:0] {
        PIXFMT_NONE  = 2'd0,
        PIXFMT_16    = 2'd1,
        PIXFMT_32    = 2'd2,
        PIXFMT_RSVD  = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic [FF_PITCH_W-1:0] pitch;
        logic [FF_WORDS_W-1:0] words;
        logic [FF_LINES_W-1:0] lines;
    } frame_geom_t;

    function automatic logic fmt_supported(input logic [1:0] code);
        return (code == PIXFMT_16) || (code == PIXFMT_32);
    endfunction
endpackage

// File: rtl/fb_fill_gate.sv
module fb_fill_gate
    import fb_fetch_pkg::*;
#(
    parameter int LVL_W = FF_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] refill_mark,
    input  logic [LVL_W-1:0] stop_mark,
    output logic             grant
);
    logic running_q;
    logic resume_now;
    logic below_stop;

    always_comb begin
        resume_now = running_q || (level <= refill_mark);
        below_stop = (level < stop_mark);
        grant      = active && resume_now && below_stop;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            running_q <= 1'b0;
        end else begin
            running_q <= resume_now && below_stop;
        end
    end
endmodule

// File: rtl/fb_line_seq.sv
module fb_line_seq
    import fb_fetch_pkg::*;
#(
    parameter int ADDR_W  = FF_ADDR_W,
    parameter int WORDS_W = FF_WORDS_W,
    parameter int LINES_W = FF_LINES_W,
    parameter int WB_LOG2 = FF_WORD_BYTES_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  frame_geom_t       geom_in,
    input  logic              fmt_ok,
    input  logic              advance,
    output logic              busy,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int OFS_W = WORDS_W + WB_LOG2;

    frame_geom_t        geom_q;
    logic [ADDR_W-1:0]  line_addr_q;
    logic [WORDS_W-1:0] word_idx_q;
    logic [LINES_W-1:0] line_idx_q;
    logic               last_word;
    logic               last_line;
    logic [OFS_W-1:0]   byte_ofs;

    always_comb begin
        last_word = (word_idx_q == geom_q.words - 1'b1);
        last_line = (line_idx_q == geom_q.lines - 1'b1);
        byte_ofs  = {word_idx_q, {WB_LOG2{1'b0}}};
        word_addr = line_addr_q + ADDR_W'(byte_ofs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            geom_q      <= '0;
            line_addr_q <= '0;
            word_idx_q  <= '0;
            line_idx_q  <= '0;
        end else if (start) begin
            geom_q      <= geom_in;
            line_addr_q <= base_in;
            word_idx_q  <= '0;
            line_idx_q  <= '0;
            busy        <= fmt_ok && (geom_in.words != '0) && (geom_in.lines != '0);
        end else if (busy && advance) begin
            if (last_word) begin
                word_idx_q  <= '0;
                line_addr_q <= line_addr_q + ADDR_W'(geom_q.pitch);
                if (last_line) begin
                    busy <= 1'b0;
                end else begin
                    line_idx_q <= line_idx_q + 1'b1;
                end
            end else begin
                word_idx_q <= word_idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fb_fetch_agen.sv
module fb_fetch_agen
    import fb_fetch_pkg::*;
#(
    parameter int ADDR_W  = FF_ADDR_W,
    parameter int PITCH_W = FF_PITCH_W,
    parameter int WORDS_W = FF_WORDS_W,
    parameter int LINES_W = FF_LINES_W,
    parameter int LVL_W   = FF_LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic [WORDS_W-1:0] cfg_words,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic [1:0]         cfg_fmt,
    input  logic [LVL_W-1:0]   thr_refill,
    input  logic [LVL_W-1:0]   thr_stop,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic               frame_busy,
    output logic               pix32
);
    frame_geom_t geom_in;
    logic        fmt_ok;
    logic        grant;
    logic        take;

    always_comb begin
        geom_in.pitch = cfg_pitch;
        geom_in.words = cfg_words;
        geom_in.lines = cfg_lines;
        fmt_ok        = fmt_supported(cfg_fmt);
        req_valid     = grant;
        take          = grant && req_ready && !frame_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix32 <= 1'b0;
        end else if (frame_start) begin
            pix32 <= (cfg_fmt == PIXFMT_32);
        end
    end

    fb_line_seq #(
        .ADDR_W (ADDR_W),
        .WORDS_W(WORDS_W),
        .LINES_W(LINES_W),
        .WB_LOG2(FF_WORD_BYTES_LOG2)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_start),
        .base_in  (cfg_base),
        .geom_in  (geom_in),
        .fmt_ok   (fmt_ok),
        .advance  (take),
        .busy     (frame_busy),
        .word_addr(req_addr)
    );

    fb_fill_gate #(
        .LVL_W(LVL_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .active     (frame_busy),
        .level      (fifo_level),
        .refill_mark(thr_refill),
        .stop_mark  (thr_stop),
        .grant      (grant)
    );
endmodule

module fb_fetch_agen_chk #(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic [1:0]        cfg_fmt,
    input logic [LVL_W-1:0]  thr_stop,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              frame_busy
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) rst |=> (!frame_busy && !req_valid));

    // R5
    no_req_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_busy |-> !req_valid);

    // R9
    stop_mark_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (fifo_level < thr_stop));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !frame_start) |=> $stable(req_addr));

    // R7
    bad_fmt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && (cfg_fmt == 2'd0 || cfg_fmt == 2'd3)) |=> !frame_busy);
endmodule

bind fb_fetch_agen fb_fetch_agen_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .cfg_fmt    (cfg_fmt),
    .thr_stop   (thr_stop),
    .fifo_level (fifo_level),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .frame_busy (frame_busy)
);

// File: tb/fb_fetch_agen_tb.sv
module fb_fetch_agen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [31:0] cfg_base = 32'h0000_1000;
    logic [15:0] cfg_pitch = 16'h0140;
    logic [9:0]  cfg_words = 10'd3;
    logic [11:0] cfg_lines = 12'd4;
    logic [1:0]  cfg_fmt = 2'd1;
    logic [7:0]  thr_refill = 8'd4;
    logic [7:0]  thr_stop = 8'd8;
    logic [7:0]  fifo_level = 8'd0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        frame_busy;
    logic        pix32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] log_a [0:255];
    int log_n = 0;

    always #4 clk = ~clk;

    fb_fetch_agen u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cfg_base(cfg_base), .cfg_pitch(cfg_pitch), .cfg_words(cfg_words),
        .cfg_lines(cfg_lines), .cfg_fmt(cfg_fmt), .thr_refill(thr_refill),
        .thr_stop(thr_stop), .fifo_level(fifo_level), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .frame_busy(frame_busy),
        .pix32(pix32)
    );

    always @(posedge clk) begin
        if (!rst && req_valid && req_ready && !frame_start) begin
            if (log_n < 256) log_a[log_n] <= req_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // checks all addresses of one logged frame from index s
    task automatic chk_frame(input string req, input int s, input logic [31:0] b,
                             input logic [31:0] p, input int w, input int l);
        chk({req, " count"}, 32'(log_n - s), 32'(w * l));
        for (int li = 0; li < l; li++)
            for (int wi = 0; wi < w; wi++)
                chk(req, log_a[s + li * w + wi], b + 32'(li) * p + 32'(wi * 16));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_cyc(3);
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 frame_busy", 32'(frame_busy), 0);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 idle after release", 32'(frame_busy), 0);
    endtask

    task automatic t_basic();
        int s;
        req_ready = 1'b1; fifo_level = 8'd0; cfg_fmt = 2'd1;
        cfg_base = 32'h0000_1000; cfg_pitch = 16'h0140;
        s = log_n;
        pulse_frame();
        chk("R2 busy", 32'(frame_busy), 1);
        chk("R2 first addr", req_addr, 32'h0000_1000);
        chk("R7 pix32 for code 1", 32'(pix32), 0);
        wait_cyc(20);
        chk_frame("R3 R4 R5 basic", s, 32'h0000_1000, 32'h140, 3, 4);
        chk("R5 idle after frame", 32'(frame_busy), 0);
        chk("R5 no req after frame", 32'(req_valid), 0);
    endtask

    task automatic t_midframe_cfg();
        int s;
        req_ready = 1'b0; fifo_level = 8'd0; cfg_fmt = 2'd2;
        cfg_base = 32'h0002_0000; cfg_pitch = 16'h0100;
        cfg_words = 10'd2; cfg_lines = 12'd3;
        s = log_n;
        pulse_frame();
        chk("R7 pix32 for code 2", 32'(pix32), 1);
        cfg_base = 32'h0003_0000; cfg_pitch = 16'h0200;
        cfg_words = 10'd5; cfg_lines = 12'd1;
        req_ready = 1'b1;
        wait_cyc(20);
        chk_frame("R6 old geometry kept", s, 32'h0002_0000, 32'h100, 2, 3);
        s = log_n;
        pulse_frame();
        wait_cyc(12);
        chk_frame("R6 new base next frame", s, 32'h0003_0000, 32'h200, 5, 1);
    endtask

    task automatic t_restart();
        int s;
        req_ready = 1'b1; fifo_level = 8'd0; cfg_fmt = 2'd1;
        cfg_base = 32'h0004_0000; cfg_pitch = 16'h0040;
        cfg_words = 10'd4; cfg_lines = 12'd3;
        pulse_frame();
        wait_cyc(4);
        chk("R11 mid-frame busy", 32'(frame_busy), 1);
        cfg_base = 32'h0005_0000;
        pulse_frame();
        s = log_n;
        chk("R11 restart addr", req_addr, 32'h0005_0000);
        wait_cyc(20);
        chk_frame("R11 restarted frame", s, 32'h0005_0000, 32'h40, 4, 3);
    endtask

    task automatic t_gate();
        int s;
        logic [31:0] a0;
        req_ready = 1'b0; fifo_level = 8'd6; thr_refill = 8'd4; thr_stop = 8'd8;
        cfg_base = 32'h0006_0000; cfg_pitch = 16'h0080;
        cfg_words = 10'd2; cfg_lines = 12'd2;
        s = log_n;
        pulse_frame();
        chk("R8 held above refill", 32'(req_valid), 0);
        @(negedge clk); fifo_level = 8'd4; #1;
        chk("R8 starts at refill", 32'(req_valid), 1);
        a0 = req_addr;
        @(negedge clk); fifo_level = 8'd6; #1;
        chk("R9 running in band", 32'(req_valid), 1);
        chk("R10 addr held", req_addr, a0);
        @(negedge clk); fifo_level = 8'd8; #1;
        chk("R9 stop at mark", 32'(req_valid), 0);
        @(negedge clk); fifo_level = 8'd6; #1;
        chk("R9 paused in band", 32'(req_valid), 0);
        @(negedge clk); fifo_level = 8'd2; #1;
        chk("R8 resume below refill", 32'(req_valid), 1);
        chk("R10 addr still held", req_addr, 32'h0006_0000);
        req_ready = 1'b1; fifo_level = 8'd0;
        wait_cyc(10);
        chk_frame("R8 gated frame", s, 32'h0006_0000, 32'h80, 2, 2);
    endtask

    task automatic t_badfmt();
        int s;
        req_ready = 1'b1; fifo_level = 8'd0;
        s = log_n;
        cfg_fmt = 2'd0;
        pulse_frame();
        chk("R7 code 0 idle", 32'(frame_busy), 0);
        cfg_fmt = 2'd3;
        pulse_frame();
        wait_cyc(3);
        chk("R7 code 3 idle", 32'(frame_busy), 0);
        chk("R7 no requests", 32'(log_n - s), 0);
        cfg_fmt = 2'd1;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_midframe_cfg();
        t_restart();
        t_gate();
        t_badfmt();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule